// File: doc/BRIEF.md
# Internal Bus Show Cycle Generator

This block makes internal bus traffic visible on an external bus so that a debugger or logic analyser can follow what the core is doing. It watches two internal buses: the instruction-fetch bus and the load/store data bus. Each bus has one holding entry. A captured transfer is kept there until the external bus is granted and idle. The block then drives a short, self-terminated show cycle on the external pins.

Fetch show cycles carry only an address. They are captured as soon as the fetch request appears, and they are captured even if the fetch is later abandoned. Data-side show cycles are captured only when the internal access completes without being aborted. They carry both address and data: an address phase followed one clock later by a data phase, which always looks like a write. When a bus's holding entry is occupied, that bus is stalled. Whether a transfer is shown depends only on the enable of the bus that started it.

Top module: `show_cycle_gen`

## Requirements
- R1: A fetch request (`if_req_i` high, fetch show enabled, entry free) is captured at that clock edge. With grant high and the external bus free, `ext_ts_o` is high in the second clock after the request clock, with the captured address. During that clock `ext_wr_o` is low and `ext_data_oe_o` is low, and no data phase follows.
- R2: A data-side transfer is captured only on a clock where `ls_done_i` is high and `ls_abort_i` is low. Its show cycle has an address phase (`ext_ts_o` high), then, exactly one clock later, a data phase: `ext_data_oe_o` high, `ext_ts_o` low, and `ext_data_o` equal to `ls_data_i` as it was at completion.
- R3: A fetch request presented with `if_abort_i` high is still shown, exactly as in R1.
- R4: A data completion presented with `ls_abort_i` high produces no show cycle and does not occupy the holding entry.
- R5: `ext_wr_o` is high in both phases of a data-side show cycle, whatever the value of `ls_wr_i`. It is low in fetch show cycles.
- R6: `ext_ts_o` is high for exactly one clock per show cycle. `ext_burst_o` is always low. `ext_ack_i` has no effect: a show cycle ends after its fixed phases.
- R7: A show cycle starts only from idle, on a clock edge where `ext_grant_i` is high and `ext_busy_i` is low. Until then, entries are held.
- R8: `if_stall_o` / `ls_stall_o` is high while that bus's holding entry is occupied. The entry is released when its address phase is issued. A transfer presented while its bus is stalled is not captured.
- R9: Capture depends only on the initiating bus's enable (`if_show_en_i` for fetches, `ls_show_en_i` for data accesses). With one enabled and the other disabled, only the enabled bus's transfers are shown.
- R10: When both entries are occupied, the earlier-captured entry is issued first. Entries captured on the same clock issue data-side first.
- R11: After reset, `ext_ts_o`, `ext_data_oe_o`, `ext_wr_o` and both stall outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| if_show_en_i | input | 1 | Enable fetch-side show cycles |
| ls_show_en_i | input | 1 | Enable data-side show cycles |
| if_req_i | input | 1 | Fetch request valid |
| if_abort_i | input | 1 | Fetch abandoned (does not suppress showing) |
| if_addr_i | input | AW | Fetch address |
| if_ct_i | input | CW | Fetch cycle type |
| if_at_i | input | TW | Fetch address type |
| if_stall_o | output | 1 | Stall to fetch bus; holding entry occupied |
| ls_done_i | input | 1 | Data access completes this clock |
| ls_abort_i | input | 1 | Data access aborted |
| ls_wr_i | input | 1 | Original direction of the data access |
| ls_addr_i | input | AW | Data access address |
| ls_ct_i | input | CW | Data access cycle type |
| ls_at_i | input | TW | Data access address type |
| ls_data_i | input | DW | Data transferred by the access |
| ls_stall_o | output | 1 | Stall to data bus; holding entry occupied |
| ext_grant_i | input | 1 | External bus granted |
| ext_busy_i | input | 1 | Another external transaction in progress |
| ext_ack_i | input | 1 | External acknowledge (ignored) |
| ext_ts_o | output | 1 | Transfer start, address phase |
| ext_addr_o | output | AW | Show cycle address |
| ext_ct_o | output | CW | Show cycle type |
| ext_at_o | output | TW | Show address type |
| ext_burst_o | output | 1 | Burst indication, held low |
| ext_wr_o | output | 1 | Write indication |
| ext_data_o | output | DW | Show data |
| ext_data_oe_o | output | 1 | Data phase active |

## Verification
The assertions check four things on every cycle. Transfer start never lasts two clocks. A data phase is always preceded by an address phase. No show cycle starts without a grant on a free bus. A holding entry is never written while occupied, and never released while empty. Only the bench scenarios can show the value-level behaviour: that aborted fetches are shown while aborted data accesses are not, that the data phase always carries write polarity and the completion data, that enables act per initiating bus, and that age order decides the issue sequence.

// File: rtl/show_pkg.sv
package show_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } show_state_e;
endpackage

// File: rtl/show_hold.sv
module show_hold #(
  parameter int AW       = 32,
  parameter int CW       = 4,
  parameter int TW       = 2,
  parameter int DW       = 32,
  parameter bit HAS_DATA = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] ct_i,
  input  logic [TW-1:0] at_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] ct_o,
  output logic [TW-1:0] at_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      ct_o    <= '0;
      at_o    <= '0;
    end else if (cap_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      ct_o    <= ct_i;
      at_o    <= at_i;
    end else if (pop_i) begin
      valid_o <= 1'b0;
    end
  end

  generate
    if (HAS_DATA) begin : g_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    data_o <= '0;
        else if (cap_i) data_o <= data_i;
      end
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^data_i;
      assign data_o      = '0;
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !valid_o); // R8
  AST_POP_OCCUPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o); // R7
endmodule

// File: rtl/show_arb.sv
module show_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic if_cap_i,
  input  logic ls_cap_i,
  input  logic if_v_i,
  input  logic ls_v_i,
  output logic pick_ls_o
);
  logic older_if_q;

  // older_if_q is meaningful only while both entries are occupied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  older_if_q <= 1'b0;
    else if (if_cap_i && ls_cap_i) older_if_q <= 1'b0;
    else if (if_cap_i)            older_if_q <= !ls_v_i;
    else if (ls_cap_i)            older_if_q <= if_v_i;
  end

  assign pick_ls_o = ls_v_i && (!if_v_i || !older_if_q);
endmodule

// File: rtl/show_engine.sv
module show_engine
  import show_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int TW = 2,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          grant_i,
  input  logic          busy_i,
  input  logic          if_v_i,
  input  logic          ls_v_i,
  input  logic          pick_ls_i,
  input  logic [AW-1:0] if_addr_i,
  input  logic [CW-1:0] if_ct_i,
  input  logic [TW-1:0] if_at_i,
  input  logic [AW-1:0] ls_addr_i,
  input  logic [CW-1:0] ls_ct_i,
  input  logic [TW-1:0] ls_at_i,
  input  logic [DW-1:0] ls_data_i,
  output logic          pop_if_o,
  output logic          pop_ls_o,
  output logic          ext_ts_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [CW-1:0] ext_ct_o,
  output logic [TW-1:0] ext_at_o,
  output logic          ext_burst_o,
  output logic          ext_wr_o,
  output logic [DW-1:0] ext_data_o,
  output logic          ext_data_oe_o
);
  show_state_e   state_q;
  logic          is_ls_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] ct_q;
  logic [TW-1:0] at_q;
  logic [DW-1:0] data_q;
  logic          launch;

  assign launch   = (state_q == ST_IDLE) && grant_i && !busy_i && (if_v_i || ls_v_i);
  assign pop_if_o = launch && !pick_ls_i;
  assign pop_ls_o = launch && pick_ls_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      is_ls_q <= 1'b0;
      addr_q  <= '0;
      ct_q    <= '0;
      at_q    <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_ADDR;
          is_ls_q <= pick_ls_i;
          addr_q  <= pick_ls_i ? ls_addr_i : if_addr_i;
          ct_q    <= pick_ls_i ? ls_ct_i   : if_ct_i;
          at_q    <= pick_ls_i ? ls_at_i   : if_at_i;
          data_q  <= pick_ls_i ? ls_data_i : '0;
        end
        ST_ADDR: state_q <= is_ls_q ? ST_DATA : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // phases end on their own; no external termination
  assign ext_ts_o      = (state_q == ST_ADDR);
  assign ext_data_oe_o = (state_q == ST_DATA);
  assign ext_addr_o    = ext_ts_o ? addr_q : '0;
  assign ext_ct_o      = ext_ts_o ? ct_q : '0;
  assign ext_at_o      = ext_ts_o ? at_q : '0;
  assign ext_burst_o   = 1'b0;
  assign ext_wr_o      = (ext_ts_o && is_ls_q) || ext_data_oe_o;
  assign ext_data_o    = ext_data_oe_o ? data_q : '0;

  AST_TS_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_ts_o |=> !ext_ts_o); // R6
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_data_oe_o |-> $past(ext_ts_o)); // R2
  AST_LAUNCH_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_ts_o) |-> $past(grant_i && !busy_i)); // R7
endmodule

// File: rtl/show_cycle_gen.sv
module show_cycle_gen #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int TW = 2,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          if_show_en_i,
  input  logic          ls_show_en_i,
  input  logic          if_req_i,
  input  logic          if_abort_i,
  input  logic [AW-1:0] if_addr_i,
  input  logic [CW-1:0] if_ct_i,
  input  logic [TW-1:0] if_at_i,
  output logic          if_stall_o,
  input  logic          ls_done_i,
  input  logic          ls_abort_i,
  input  logic          ls_wr_i,
  input  logic [AW-1:0] ls_addr_i,
  input  logic [CW-1:0] ls_ct_i,
  input  logic [TW-1:0] ls_at_i,
  input  logic [DW-1:0] ls_data_i,
  output logic          ls_stall_o,
  input  logic          ext_grant_i,
  input  logic          ext_busy_i,
  input  logic          ext_ack_i,
  output logic          ext_ts_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [CW-1:0] ext_ct_o,
  output logic [TW-1:0] ext_at_o,
  output logic          ext_burst_o,
  output logic          ext_wr_o,
  output logic [DW-1:0] ext_data_o,
  output logic          ext_data_oe_o
);
  logic          if_v, ls_v, if_cap, ls_cap, pop_if, pop_ls, pick_ls;
  logic [AW-1:0] if_addr_h, ls_addr_h;
  logic [CW-1:0] if_ct_h, ls_ct_h;
  logic [TW-1:0] if_at_h, ls_at_h;
  logic [DW-1:0] ls_data_h, unused_if_data;
  logic          unused_in;

  // fetch abort, original direction and acknowledge do not alter showing
  assign unused_in = ^{if_abort_i, ls_wr_i, ext_ack_i, unused_if_data};

  assign if_cap     = if_show_en_i && if_req_i && !if_v;
  assign ls_cap     = ls_show_en_i && ls_done_i && !ls_abort_i && !ls_v;
  assign if_stall_o = if_v;
  assign ls_stall_o = ls_v;

  show_hold #(.AW(AW), .CW(CW), .TW(TW), .DW(DW), .HAS_DATA(1'b0)) u_if_hold (
    .clk_i, .rst_ni, .cap_i(if_cap), .addr_i(if_addr_i), .ct_i(if_ct_i),
    .at_i(if_at_i), .data_i('0), .pop_i(pop_if), .valid_o(if_v),
    .addr_o(if_addr_h), .ct_o(if_ct_h), .at_o(if_at_h), .data_o(unused_if_data)
  );

  show_hold #(.AW(AW), .CW(CW), .TW(TW), .DW(DW), .HAS_DATA(1'b1)) u_ls_hold (
    .clk_i, .rst_ni, .cap_i(ls_cap), .addr_i(ls_addr_i), .ct_i(ls_ct_i),
    .at_i(ls_at_i), .data_i(ls_data_i), .pop_i(pop_ls), .valid_o(ls_v),
    .addr_o(ls_addr_h), .ct_o(ls_ct_h), .at_o(ls_at_h), .data_o(ls_data_h)
  );

  show_arb u_arb (
    .clk_i, .rst_ni, .if_cap_i(if_cap), .ls_cap_i(ls_cap),
    .if_v_i(if_v), .ls_v_i(ls_v), .pick_ls_o(pick_ls)
  );

  show_engine #(.AW(AW), .CW(CW), .TW(TW), .DW(DW)) u_eng (
    .clk_i, .rst_ni, .grant_i(ext_grant_i), .busy_i(ext_busy_i),
    .if_v_i(if_v), .ls_v_i(ls_v), .pick_ls_i(pick_ls),
    .if_addr_i(if_addr_h), .if_ct_i(if_ct_h), .if_at_i(if_at_h),
    .ls_addr_i(ls_addr_h), .ls_ct_i(ls_ct_h), .ls_at_i(ls_at_h), .ls_data_i(ls_data_h),
    .pop_if_o(pop_if), .pop_ls_o(pop_ls),
    .ext_ts_o, .ext_addr_o, .ext_ct_o, .ext_at_o, .ext_burst_o,
    .ext_wr_o, .ext_data_o, .ext_data_oe_o
  );

  AST_STALL_BLOCKS_IF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_stall_o && !pop_if) |=> $stable(if_addr_h)); // R8
endmodule

// File: tb/sim_show_cycle_gen.sv
module sim_show_cycle_gen;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic if_show_en, ls_show_en, if_req, if_abort, if_stall;
  logic [31:0] if_addr, ls_addr, ls_data, ext_addr, ext_data;
  logic [3:0] if_ct, ls_ct, ext_ct;
  logic [1:0] if_at, ls_at, ext_at;
  logic ls_done, ls_abort, ls_wr, ls_stall;
  logic grant, busy, ack, ts, burst, wr, oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  show_cycle_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .if_show_en_i(if_show_en), .ls_show_en_i(ls_show_en),
    .if_req_i(if_req), .if_abort_i(if_abort), .if_addr_i(if_addr), .if_ct_i(if_ct),
    .if_at_i(if_at), .if_stall_o(if_stall), .ls_done_i(ls_done), .ls_abort_i(ls_abort),
    .ls_wr_i(ls_wr), .ls_addr_i(ls_addr), .ls_ct_i(ls_ct), .ls_at_i(ls_at),
    .ls_data_i(ls_data), .ls_stall_o(ls_stall), .ext_grant_i(grant), .ext_busy_i(busy),
    .ext_ack_i(ack), .ext_ts_o(ts), .ext_addr_o(ext_addr), .ext_ct_o(ext_ct),
    .ext_at_o(ext_at), .ext_burst_o(burst), .ext_wr_o(wr), .ext_data_o(ext_data),
    .ext_data_oe_o(oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic put_if(input logic [31:0] a, input logic ab);
    if_req = 1'b1; if_addr = a; if_abort = ab; if_ct = 4'h3; if_at = 2'h1;
  endtask

  task automatic put_ls(input logic [31:0] a, input logic [31:0] d, input logic w, input logic ab);
    ls_done = 1'b1; ls_addr = a; ls_data = d; ls_wr = w; ls_abort = ab;
    ls_ct = 4'h9; ls_at = 2'h2;
  endtask

  task automatic clear_in();
    if_req = 1'b0; if_abort = 1'b0; ls_done = 1'b0; ls_abort = 1'b0;
  endtask

  // advance until an address phase appears; returns its address or DEADDEAD
  task automatic next_show(output logic [31:0] a);
    a = 32'hDEADDEAD;
    for (int i = 0; i < 10; i++) begin
      step();
      if (ts) begin a = ext_addr; break; end
    end
  endtask

  task automatic count_ts(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(); if (ts) c++; end
  endtask

  task automatic t_reset();
    check("R11 ts", {31'd0, ts}, 32'd0);
    check("R11 oe", {31'd0, oe}, 32'd0);
    check("R11 wr", {31'd0, wr}, 32'd0);
    check("R11 stalls", {30'd0, if_stall, ls_stall}, 32'd0);
  endtask

  task automatic t_fetch(input logic [31:0] a, input logic ab, input string tag);
    grant = 1'b1; busy = 1'b0;
    put_if(a, ab);
    step(); clear_in();
    check({tag, " R8 stall while held"}, {31'd0, if_stall}, 32'd1);
    step();
    check({tag, " ts"}, {31'd0, ts}, 32'd1);
    check({tag, " addr"}, ext_addr, a);
    check({tag, " ct/at"}, {26'd0, ext_ct, ext_at}, {26'd0, 4'h3, 2'h1});
    check({tag, " R5 wr low"}, {31'd0, wr}, 32'd0);
    check({tag, " R6 burst"}, {31'd0, burst}, 32'd0);
    check({tag, " no data"}, {31'd0, oe}, 32'd0);
    step();
    check({tag, " R6 ts one clk"}, {31'd0, ts}, 32'd0);
    check({tag, " R1 address only"}, {31'd0, oe}, 32'd0);
  endtask

  task automatic t_data(input logic [31:0] a, input logic [31:0] d, input logic w, input logic ak);
    grant = 1'b1; busy = 1'b0; ack = ak;
    put_ls(a, d, w, 1'b0);
    step(); clear_in();
    check("R8 ls stall while held", {31'd0, ls_stall}, 32'd1);
    step();
    check("R2 addr phase ts", {31'd0, ts}, 32'd1);
    check("R2 addr", ext_addr, a);
    check("R5 wr in addr phase", {31'd0, wr}, 32'd1);
    check("R2 no data yet", {31'd0, oe}, 32'd0);
    check("R6 burst", {31'd0, burst}, 32'd0);
    step();
    check("R6 ts dropped", {31'd0, ts}, 32'd0);
    check("R2 data phase", {31'd0, oe}, 32'd1);
    check("R2 data", ext_data, d);
    check("R5 wr in data phase", {31'd0, wr}, 32'd1);
    step();
    check("R6 ends without ack", {30'd0, oe, ts}, 32'd0);
    ack = 1'b0;
  endtask

  task automatic t_suppress();
    int c;
    logic [31:0] a;
    grant = 1'b1; busy = 1'b0;
    put_ls(32'h0000_4000, 32'h1111_2222, 1'b1, 1'b1);
    step(); clear_in();
    check("R4 aborted not held", {31'd0, ls_stall}, 32'd0);
    count_ts(6, c);
    check("R4 aborted not shown", c, 0);
    ls_show_en = 1'b0;
    put_if(32'h0000_8000, 1'b0);
    put_ls(32'h0000_9000, 32'h3333_4444, 1'b0, 1'b0);
    step(); clear_in();
    next_show(a);
    check("R9 fetch shown when data off", a, 32'h0000_8000);
    count_ts(6, c);
    check("R9 data access not shown", c, 0);
    ls_show_en = 1'b1; if_show_en = 1'b0;
    put_if(32'h0000_A000, 1'b0);
    step(); clear_in();
    count_ts(6, c);
    check("R9 fetch not shown when off", c, 0);
    if_show_en = 1'b1;
  endtask

  task automatic t_grant();
    int c;
    logic [31:0] a;
    grant = 1'b0; busy = 1'b0;
    put_if(32'h0000_1230, 1'b0);
    step(); clear_in();
    count_ts(3, c);
    check("R7 no start without grant", c, 0);
    check("R8 stall while waiting", {31'd0, if_stall}, 32'd1);
    put_if(32'h0000_4560, 1'b0);
    step(); clear_in();
    grant = 1'b1; busy = 1'b1;
    count_ts(3, c);
    check("R7 no start while busy", c, 0);
    busy = 1'b0;
    step();
    check("R7 start once free", {31'd0, ts}, 32'd1);
    check("R7 held entry", ext_addr, 32'h0000_1230);
    count_ts(6, c);
    check("R8 stalled request dropped", c, 0);
  endtask

  task automatic t_order();
    logic [31:0] a;
    grant = 1'b0;
    put_ls(32'h0000_0A00, 32'h0, 1'b0, 1'b0); step(); clear_in();
    put_if(32'h0000_0B00, 1'b0); step(); clear_in();
    grant = 1'b1;
    next_show(a); check("R10 data older first", a, 32'h0000_0A00);
    next_show(a); check("R10 fetch second", a, 32'h0000_0B00);
    grant = 1'b0;
    put_if(32'h0000_0C00, 1'b0); step(); clear_in();
    put_ls(32'h0000_0D00, 32'h0, 1'b1, 1'b0); step(); clear_in();
    grant = 1'b1;
    next_show(a); check("R10 fetch older first", a, 32'h0000_0C00);
    next_show(a); check("R10 data second", a, 32'h0000_0D00);
    grant = 1'b0;
    put_if(32'h0000_0E00, 1'b0); put_ls(32'h0000_0F00, 32'h0, 1'b0, 1'b0);
    step(); clear_in();
    grant = 1'b1;
    next_show(a); check("R10 tie data first", a, 32'h0000_0F00);
    next_show(a); check("R10 tie fetch next", a, 32'h0000_0E00);
    step(); step();
  endtask

  initial begin
    if_show_en = 1'b1; ls_show_en = 1'b1; grant = 1'b0; busy = 1'b0; ack = 1'b0;
    if_addr = '0; if_ct = '0; if_at = '0; ls_addr = '0; ls_data = '0; ls_ct = '0;
    ls_at = '0; ls_wr = 1'b0;
    clear_in();
    repeat (3) step();
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_fetch(32'h1000_0040, 1'b0, "R1 fetch");
    t_fetch(32'h1000_0080, 1'b1, "R3 aborted fetch");
    t_data(32'h2000_0010, 32'hCAFE_0001, 1'b0, 1'b0);
    t_data(32'h2000_0020, 32'hBEEF_0002, 1'b1, 1'b1);
    t_suppress();
    t_grant();
    t_order();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule